// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master running in standard mode (100 kbit/s) or fast mode (400 kbit/s). An 8-bit divider value `P` slows the functional clock down to an internal tick, one tick every `P+1` functional cycles. The tick is meant to sit near 12 MHz. Two 8-bit phase values then set how many ticks SCL spends low and high. A fixed offset is added to each: seven ticks to the low phase and five ticks to the high phase. High-speed mode, clock stretching by slaves and the bus pads are not part of this block.

The three configuration values are loaded through a small write port. They can change only while the module enable is low; a write made while the module is enabled is dropped. The waveform runs while both the module enable and the transfer engine's run request are high. If either one drops, SCL is released and every counter returns to its start value.

SCL is given as a single open-drain control: when `scl_drive_low` is high the pad pulls SCL low, and when it is low SCL is released. Two one-cycle strobes mark points in each SCL period for the data path. The first comes in the middle of the low phase, where SDA may change. The second comes when SCL rises, where SDA is sampled.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `scl_drive_low`, `tick_o`, `shift_stb` and `sample_stb` are all 0.
- R2: While running, `tick_o` pulses for one cycle every `P+1` functional cycles. The first tick comes `P` cycles after SCL is first driven low. With P=0 the tick is high on every cycle.
- R3: Each low phase of SCL lasts exactly `(L+7)*(P+1)` functional cycles, where L is the low-phase value.
- R4: Each high phase of SCL lasts exactly `(H+5)*(P+1)` functional cycles, where H is the high-phase value.
- R5: If `enable` or `run` is low, SCL is released from the next cycle on, and no tick or strobe appears. A later restart begins with a full-length low phase.
- R6: A configuration write made while `enable` is high has no effect on any later SCL timing.
- R7: A configuration write made while `enable` is low is stored. `cfg_sel` selects the value: 0 is the divider, 1 is the low-phase value, 2 is the high-phase value. Code 3 writes nothing.
- R8: `shift_stb` is high for exactly one cycle in each low phase, `floor((L+7)/2)*(P+1)` cycles after the first low cycle.
- R9: `sample_stb` is high for exactly one cycle in each high phase: the first cycle in which SCL is released after a low phase.
- R10: SCL is driven low in the cycle after the first clock edge at which `enable` and `run` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Module enable; configuration is locked while high |
| run | input | 1 | Run request from the transfer engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration select: 0 divider, 1 low phase, 2 high phase, 3 none |
| cfg_wdata | input | 8 | Configuration write data |
| tick_o | output | 1 | Internal tick, one functional cycle wide |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| shift_stb | output | 1 | Middle-of-low-phase strobe (SDA may change) |
| sample_stb | output | 1 | SCL rising-edge strobe (SDA sampled) |

## Verification
The bench builds the block with its default 8-bit register width and the package offsets of 7 and 5. With these, every divider and phase value from 0 to 255 can be written. The bench drives both ends of each range: no division (P=0, a tick on every cycle), the largest division (P=255), and the longest low phase (L=255), where the phase counter needs its ninth bit. Each phase is measured in functional cycles and compared with the formulas above. These settings also exercise a restart in the middle of a low phase and configuration writes made while the module is enabled.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Width of every configuration register
    parameter int unsigned REG_W = 8;
    // Phase counter width: register width plus room for the fixed offset
    parameter int unsigned PH_W = REG_W + 1;

    // Fixed tick offsets added to the programmed phase values
    parameter int unsigned LOW_OFS  = 7;
    parameter int unsigned HIGH_OFS = 5;

    // Number of configuration registers and their select codes
    parameter int unsigned NUM_CFG = 3;
    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_LOW  = 2'd1;
    localparam logic [1:0] SEL_HIGH = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [REG_W-1:0] div;
        logic [REG_W-1:0] low;
        logic [REG_W-1:0] high;
    } scl_cfg_t;

    // Phase length in ticks: programmed value plus fixed offset
    function automatic logic [PH_W-1:0] phase_len(input logic [REG_W-1:0] val,
                                                   input int unsigned ofs);
        return PH_W'(val) + PH_W'(ofs);
    endfunction

endpackage

// File: rtl/scl_cfg_bank.sv
module scl_cfg_bank
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output scl_cfg_t         cfg
);

    logic [REG_W-1:0] regs [NUM_CFG];

    // One register per select code; a write lands only while unlocked
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && !lock && (wr_sel == 2'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        cfg.div  = regs[SEL_DIV];
        cfg.low  = regs[SEL_LOW];
        cfg.high = regs[SEL_HIGH];
    end

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic [REG_W-1:0] div,
    output logic             tick
);

    logic [REG_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == div);
    assign tick = count_en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            tick,
    input  logic [PH_W-1:0] low_len,
    input  logic [PH_W-1:0] high_len,
    output logic            busy,
    output logic            scl_low,
    output logic            shift_stb,
    output logic            sample_stb
);

    scl_phase_e      state;
    logic [PH_W-1:0] ph_cnt;
    logic [PH_W-1:0] low_mid;
    logic            low_last;
    logic            high_last;
    logic            low_mid_hit;

    assign low_mid     = low_len >> 1;
    assign low_last    = (ph_cnt == low_len - 1'b1);
    assign high_last   = (ph_cnt == high_len - 1'b1);
    assign low_mid_hit = (ph_cnt == low_mid - 1'b1);

    assign busy    = (state != PH_IDLE);
    assign scl_low = (state == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state      <= PH_IDLE;
            ph_cnt     <= '0;
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
            case (state)
                PH_IDLE: begin
                    state  <= PH_LOW;
                    ph_cnt <= '0;
                end
                PH_LOW: begin
                    if (tick) begin
                        shift_stb <= low_mid_hit;
                        if (low_last) begin
                            state      <= PH_HIGH;
                            ph_cnt     <= '0;
                            sample_stb <= 1'b1;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (high_last) begin
                            state  <= PH_LOW;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state  <= PH_IDLE;
                    ph_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             tick_o,
    output logic             scl_drive_low,
    output logic             shift_stb,
    output logic             sample_stb
);

    scl_cfg_t        cfg;
    logic            active;
    logic            busy;
    logic            tick;
    logic [PH_W-1:0] low_len;
    logic [PH_W-1:0] high_len;

    assign active   = enable && run;
    assign low_len  = phase_len(cfg.low, LOW_OFS);
    assign high_len = phase_len(cfg.high, HIGH_OFS);
    assign tick_o   = tick;

    scl_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .lock    (enable),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    scl_tick_div u_div (
        .clk      (clk),
        .rst      (rst),
        .count_en (active && busy),
        .div      (cfg.div),
        .tick     (tick)
    );

    scl_phase_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .tick       (tick),
        .low_len    (low_len),
        .high_len   (high_len),
        .busy       (busy),
        .scl_low    (scl_drive_low),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk
    import scl_gen_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     enable,
    input logic     run,
    input logic     tick_o,
    input logic     scl_drive_low,
    input logic     shift_stb,
    input logic     sample_stb,
    input scl_cfg_t cfg
);

    // R10 / R5: SCL is only pulled low after an edge where the block was running
    a_r10_low_needs_run: assert property (@(posedge clk) disable iff (rst)
        scl_drive_low |-> $past(enable && run));

    // R5: no tick while stopped
    a_r5_tick_gated: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (enable && run));

    // R9: sample strobe on the first released cycle after a low phase
    a_r9_sample_on_rise: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (!scl_drive_low && $past(scl_drive_low)));

    // R8: shift strobe lies inside a low phase, never on its first cycle
    a_r8_shift_in_low: assert property (@(posedge clk) disable iff (rst)
        shift_stb |-> (scl_drive_low && $past(scl_drive_low)));

    // R8 / R9: the two strobes never coincide
    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        !(shift_stb && sample_stb));

    // R6: configuration holds while the module stays enabled
    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> $stable(cfg));

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .run           (run),
    .tick_o        (tick_o),
    .scl_drive_low (scl_drive_low),
    .shift_stb     (shift_stb),
    .sample_stb    (sample_stb),
    .cfg           (cfg)
);

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       tick_o;
    logic       scl_drive_low;
    logic       shift_stb;
    logic       sample_stb;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_clock_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .run           (run),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .tick_o        (tick_o),
        .scl_drive_low (scl_drive_low),
        .shift_stb     (shift_stb),
        .sample_stb    (sample_stb)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [1:0] sel, logic [7:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic configure(int p, int l, int h);
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
        write_reg(2'd0, 8'(p));
        write_reg(2'd1, 8'(l));
        write_reg(2'd2, 8'(h));
    endtask

    // Start running, measure one full SCL period, then stop
    task automatic run_measure(string tag, int p, int l, int h);
        int lc = 0, hc = 0, ticks = 0, first_tick = -1;
        int shift_at = -1, shifts = 0, samples = 0;
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        check({"R10 low after start ", tag}, int'(scl_drive_low), 1);
        while (scl_drive_low === 1'b1 && lc < 70000) begin
            if (tick_o) begin
                if (first_tick < 0) first_tick = lc;
                ticks++;
            end
            if (shift_stb) begin shifts++; shift_at = lc; end
            if (sample_stb) samples++;
            lc++;
            @(negedge clk);
        end
        check({"R3 low length ", tag}, lc, (l + 7) * (p + 1));
        check({"R2 ticks in low ", tag}, ticks, l + 7);
        check({"R2 first tick ", tag}, first_tick, p);
        check({"R8 shift count ", tag}, shifts, 1);
        check({"R8 shift position ", tag}, shift_at, ((l + 7) / 2) * (p + 1));
        check({"R9 sample on rise ", tag}, int'(sample_stb), 1);
        while (scl_drive_low === 1'b0 && hc < 70000) begin
            if (sample_stb) samples++;
            if (shift_stb) shifts++;
            hc++;
            @(negedge clk);
        end
        check({"R4 high length ", tag}, hc, (h + 5) * (p + 1));
        check({"R9 sample count ", tag}, samples, 1);
        run = 1'b0;
        @(negedge clk);
        check({"R5 released after stop ", tag}, int'(scl_drive_low), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 scl in reset", int'(scl_drive_low), 0);
        check("R1 tick in reset", int'(tick_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 scl after reset", int'(scl_drive_low), 0);
        check("R1 strobes after reset", int'(shift_stb) + int'(sample_stb), 0);
    endtask

    task automatic t_patterns();
        configure(0, 0, 0);   run_measure("p0 l0 h0", 0, 0, 0);
        configure(1, 2, 3);   run_measure("p1 l2 h3", 1, 2, 3);
        configure(3, 10, 4);  run_measure("p3 l10 h4", 3, 10, 4);
    endtask

    task automatic t_boundary();
        configure(0, 255, 255); run_measure("max phases", 0, 255, 255);
        configure(255, 0, 0);   run_measure("max divider", 255, 0, 0);
    endtask

    task automatic t_locked_writes();
        configure(1, 2, 3);
        enable = 1'b1;
        @(negedge clk);
        write_reg(2'd0, 8'd9);
        write_reg(2'd1, 8'd20);
        write_reg(2'd2, 8'd30);
        run_measure("R6 writes while enabled", 1, 2, 3);
    endtask

    task automatic t_unused_sel();
        configure(2, 1, 6);
        write_reg(2'd3, 8'd40);
        run_measure("R7 select code 3", 2, 1, 6);
    endtask

    task automatic t_stop_restart();
        int t = 0;
        configure(1, 4, 2);
        enable = 1'b1; run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R5 run drop releases", int'(scl_drive_low), 0);
        repeat (3) begin
            t += int'(tick_o) + int'(shift_stb) + int'(sample_stb);
            @(negedge clk);
        end
        check("R5 quiet while stopped", t, 0);
        run_measure("R5 restart after run drop", 1, 4, 2);
        enable = 1'b1; run = 1'b1;
        repeat (7) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R5 enable drop releases", int'(scl_drive_low), 0);
        check("R5 no tick when disabled", int'(tick_o), 0);
        run = 1'b0;
        run_measure("R5 restart after disable", 1, 4, 2);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_boundary();
        t_locked_writes();
        t_unused_sel();
        t_stop_restart();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule